// File: doc/BRIEF.md
# Sleep-Aware Watchdog Timer

This block is a watchdog that counts ticks from its own free-running time base. That time base is independent of the processor clock, so the watchdog keeps counting while the core sleeps with its main clock stopped. Software must keep it from expiring. It does this by pulsing a clear strobe often enough. Entering sleep clears it in the same way.

When the count runs out, the outcome depends on the core's state. If the core is awake, the block raises a one-tick reset request. If the core is asleep, it raises a one-tick wake request instead, and execution carries on. Either way, an active-high "still alive" flag drops to 0, so software can later tell that the watchdog caused the event.

An optional power-of-two prescaler can be placed in front of the counter to stretch the period. The ratio is set by a 3-bit select field. A configuration enable turns the whole watchdog off. All inputs are taken as synchronous to the watchdog tick.

Top module: `sleep_watchdog`

## Requirements
- R1: While `por_n` is low, and on the first tick after it rises, `rst_req` and `wake_req` are 0 and `alive` is 1. The counter and prescaler start from zero, so with the prescaler unassigned and no clear, the first time-out occurs on the BASE_TICKS-th tick after reset release.
- R2: With `psc_on` = 0, the period is exactly BASE_TICKS ticks after a clear, whatever value `psc_sel` holds.
- R3: With `psc_on` = 1, the period is BASE_TICKS × 2^`psc_sel` ticks after a clear (`psc_sel` = 0 gives ×1, and 7 gives ×128).
- R4: A tick with `kick` = 1 zeroes the counter and, when assigned, the prescaler. It produces no time-out on that tick and sets `alive` to 1.
- R5: A tick with `sleep_go` = 1 has the same effect as `kick`.
- R6: A time-out with `asleep` = 0 gives `rst_req` = 1 for exactly one tick, with `wake_req` = 0.
- R7: A time-out with `asleep` = 1 gives `wake_req` = 1 for exactly one tick, with `rst_req` = 0.
- R8: A time-out sets `alive` to 0. It stays 0 until a `kick` or `sleep_go` tick.
- R9: While `wd_on` = 0, the counter and prescaler hold their values and no request is raised. Counting resumes from the held value when `wd_on` returns to 1.
- R10: After a time-out, counting restarts from zero, so the next time-out follows one full period later.
- R11: A clear on the tick that would otherwise be the terminal count wins: no request is raised and `alive` ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wd_clk | input | 1 | Free-running watchdog tick |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wd_on | input | 1 | Configuration enable; 0 disables the watchdog |
| kick | input | 1 | Software clear strobe |
| sleep_go | input | 1 | Sleep-entry strobe, clears like `kick` |
| asleep | input | 1 | Level: core is in sleep |
| psc_on | input | 1 | 1 = prescaler assigned to the watchdog |
| psc_sel | input | 3 | Prescale ratio select, divide by 2^value |
| rst_req | output | 1 | One-tick device reset request |
| wake_req | output | 1 | One-tick wake-up request |
| alive | output | 1 | Status: 0 after a time-out, 1 after a clear or reset |

## Verification
The hardest case to reach from the ports is a clear that lands on exactly the terminal tick (R11). Random clear strobes almost never meet that one cycle at long prescale ratios. The bench therefore drives a directed run of BASE_TICKS−1 quiet ticks and then kicks, and it repeats this with the prescaler assigned. Long periods at a ratio of 128 are reached by building the bench with a small BASE_TICKS. Random traffic changes the ratio only together with a clear, and mixes sleep level, sleep entry and enable toggles against a tick-count model.

// File: rtl/sleep_watchdog.sv
module sleep_watchdog #(
  parameter int BASE_TICKS = 1024,
  parameter int SEL_W      = 3
) (
  input  logic             wd_clk,
  input  logic             por_n,
  input  logic             wd_on,
  input  logic             kick,
  input  logic             sleep_go,
  input  logic             asleep,
  input  logic             psc_on,
  input  logic [SEL_W-1:0] psc_sel,
  output logic             rst_req,
  output logic             wake_req,
  output logic             alive
);
  localparam int PW = (1 << SEL_W) - 1;
  localparam int CW = $clog2(BASE_TICKS);

  logic [PW-1:0] psc;
  logic [CW-1:0] cnt;
  logic [PW:0]   ratio;
  logic [PW-1:0] mask;
  logic          step, hit, clr;

  assign ratio = (PW+1)'(1) << psc_sel;
  assign mask  = psc_on ? PW'(ratio - 1'b1) : '0;
  assign step  = psc >= mask;
  assign hit   = step && (cnt == CW'(BASE_TICKS - 1));
  assign clr   = kick | sleep_go;

  always_ff @(posedge wd_clk or negedge por_n) begin
    if (!por_n) begin
      psc      <= '0;
      cnt      <= '0;
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      alive    <= 1'b1;
    end else begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      if (clr) begin
        cnt   <= '0;
        alive <= 1'b1;
        if (psc_on) psc <= '0;
      end else if (wd_on) begin
        psc <= step ? '0 : psc + 1'b1;
        if (hit) begin
          cnt      <= '0;
          alive    <= 1'b0;
          rst_req  <= !asleep;
          wake_req <= asleep;
        end else if (step) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sleep_watchdog_props.sv
module sleep_watchdog_props (
  input logic wd_clk,
  input logic por_n,
  input logic wd_on,
  input logic kick,
  input logic sleep_go,
  input logic asleep,
  input logic rst_req,
  input logic wake_req,
  input logic alive
);
  p_excl_r6: assert property (@(posedge wd_clk) disable iff (!por_n)
    !(rst_req && wake_req));
  p_rst_once_r6: assert property (@(posedge wd_clk) disable iff (!por_n)
    rst_req |=> !rst_req);
  p_rst_awake_r6: assert property (@(posedge wd_clk) disable iff (!por_n)
    rst_req |-> $past(!asleep));
  p_wake_once_r7: assert property (@(posedge wd_clk) disable iff (!por_n)
    wake_req |=> !wake_req);
  p_wake_asleep_r7: assert property (@(posedge wd_clk) disable iff (!por_n)
    wake_req |-> $past(asleep));
  p_flag_drop_r8: assert property (@(posedge wd_clk) disable iff (!por_n)
    (rst_req || wake_req) |-> !alive);
  p_flag_rise_r8: assert property (@(posedge wd_clk) disable iff (!por_n)
    $rose(alive) |-> $past(kick || sleep_go));
  p_kick_r4: assert property (@(posedge wd_clk) disable iff (!por_n)
    kick |=> (alive && !rst_req && !wake_req));
  p_sleep_r5: assert property (@(posedge wd_clk) disable iff (!por_n)
    sleep_go |=> (alive && !rst_req && !wake_req));
  p_off_r9: assert property (@(posedge wd_clk) disable iff (!por_n)
    !wd_on |=> (!rst_req && !wake_req));
endmodule

bind sleep_watchdog sleep_watchdog_props u_props (
  .wd_clk(wd_clk), .por_n(por_n), .wd_on(wd_on), .kick(kick),
  .sleep_go(sleep_go), .asleep(asleep), .rst_req(rst_req),
  .wake_req(wake_req), .alive(alive)
);

// File: tb/sim_sleep_watchdog.sv
`timescale 1ns/1ps
module sim_sleep_watchdog;
  localparam int B = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic wd_on = 1'b0, kick = 1'b0, sleep_go = 1'b0, asleep = 1'b0, psc_on = 1'b0;
  logic [2:0] psc_sel = 3'd0;
  logic rst_req, wake_req, alive;

  int checks = 0, fails = 0;
  int el = 0;
  logic er = 1'b0, ew = 1'b0, ef = 1'b1;
  string tag = "R1";

  always #4 clk = ~clk;

  sleep_watchdog #(.BASE_TICKS(B)) u0 (
    .wd_clk(clk), .por_n(por_n), .wd_on(wd_on), .kick(kick), .sleep_go(sleep_go),
    .asleep(asleep), .psc_on(psc_on), .psc_sel(psc_sel),
    .rst_req(rst_req), .wake_req(wake_req), .alive(alive)
  );

  function automatic int period(logic a, logic [2:0] s);
    return a ? (B << s) : B;
  endfunction

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("rst_req", rst_req, er);
    chk("wake_req", wake_req, ew);
    chk("alive", alive, ef);
  endtask

  task automatic cyc(logic en, logic k, logic sg, logic slp);
    wd_on = en; kick = k; sleep_go = sg; asleep = slp;
    er = 1'b0; ew = 1'b0;
    if (k || sg) begin
      el = 0; ef = 1'b1;
    end else if (en) begin
      el++;
      if (el == period(psc_on, psc_sel)) begin
        el = 0; ef = 1'b0; er = !slp; ew = slp;
      end
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic cfg(logic a, logic [2:0] s);
    psc_on = a; psc_sel = s;
    cyc(1'b1, 1'b1, 1'b0, asleep);
  endtask

  task automatic run(int n, logic slp);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, slp);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check_all();
    por_n = 1'b1;
    // R1: first time-out B ticks after release with defaults
    run(B + 3, 1'b0);

    tag = "R2";
    cfg(1'b0, 3'd5);
    run(2 * B + 2, 1'b0);

    tag = "R3";
    cfg(1'b1, 3'd3);
    run(B * 8 + 4, 1'b0);
    cfg(1'b1, 3'd7);
    run(B * 128 + 4, 1'b0);

    tag = "R11";
    cfg(1'b0, 3'd0);
    run(B - 1, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    run(B - 1, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    cfg(1'b1, 3'd2);
    run(B * 4 - 1, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);

    tag = "R4";
    run(B - 2, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    run(B * 4 + 2, 1'b0);

    tag = "R7";
    cyc(1'b1, 1'b0, 1'b1, 1'b1);
    run(B * 4 + 2, 1'b1);

    tag = "R5";
    run(3, 1'b1);
    cyc(1'b1, 1'b0, 1'b1, 1'b1);
    run(5, 1'b1);

    tag = "R9";
    for (int i = 0; i < 60; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    run(B * 4 + 2, 1'b0);

    tag = "R10";
    run(B * 4 * 3 + 1, 1'b0);

    tag = "R6";
    cfg(1'b0, 3'd0);
    run(3 * B, 1'b0);

    tag = "R8";
    run(2, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);

    tag = "R6 R7 R8";
    void'($urandom(32'h5eed_1234));
    begin
      logic en = 1'b1, slp = 1'b0;
      for (int i = 0; i < 30000; i++) begin
        if ($urandom_range(199) == 0) en = !en;
        if ($urandom_range(99) == 0) slp = !slp;
        if ($urandom_range(59) == 0) begin
          psc_on = 1'($urandom_range(1));
          psc_sel = 3'($urandom_range(4));
          cyc(en, 1'b1, 1'b0, slp);
        end else if ($urandom_range(399) == 0) begin
          cyc(en, 1'b0, 1'b1, slp);
        end else begin
          cyc(en, 1'b0, 1'b0, slp);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule